// File: doc/BRIEF.md
# Double-Buffered SPI Master with Status Flags

This block is a byte-oriented SPI master that sits behind a simple strobe interface. Software places a byte in a transmit holding register. The control state machine moves that byte into a shift register, which frees the holding register for the next byte. The byte is then shifted out most significant bit first on `mosi`, while the byte arriving on `miso` is gathered. Each completed received byte is handed to a receive holding register. Sticky flags tell software when the transmit side wants a new byte, when a received byte is waiting, and when a received byte arrived before the previous one was read.

Clock polarity and phase are selectable. The serial clock half period is `cfg_half + 1` system clocks, so the divide ratio is always even and at least 2. Two start policies exist:
- **Transmit-initiated** (`cfg_txmode = 1`): bytes run only from written data, and the link stops at a byte boundary when the holding register is empty.
- **Read-initiated** (`cfg_txmode = 0`): a read of the receive register also requests one more byte. If no data was written, the fill byte 0xFF is sent.

Behaviour when a byte arrives while the previous one is still unread is also selectable. The new byte is dropped when `cfg_overwrite = 0` and replaces the old one when `cfg_overwrite = 1`. A timing bit can move the receive hand-off half a serial clock period earlier.

State machine:
- **States:** `ST_IDLE` (select high, clock parked), `ST_LEAD` (select low for one half period), `ST_SHIFT` (16 half periods per byte), `ST_TRAIL` (one half period before select rises).
- **Transitions:**
  - *start*: IDLE to LEAD, when a byte is available.
  - *launch*: LEAD to SHIFT, on a half-period tick.
  - *chain*: SHIFT to SHIFT, at the byte's last tick when another byte is available. The next byte is loaded.
  - *drain*: SHIFT to TRAIL, at the byte's last tick when nothing is pending.
  - *release*: TRAIL to IDLE, on a tick.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset `ss_n` is 1, `sclk` equals `cfg_cpol`, and `irq_tx`, `irq_rx`, `flag_ovf` and `busy` are 0.
- R2: Each frame is 8 bits, sent most significant bit first on `mosi` and received most significant bit first from `miso`. While `ss_n` is 1, `sclk` rests at `cfg_cpol`.
- R3: With `cfg_cpha = 0`, `miso` is sampled on the first `sclk` edge of each bit and `mosi` changes on the second. With `cfg_cpha = 1`, `mosi` is valid from the first edge and `miso` is sampled on the second.
- R4: Each `sclk` level inside a byte lasts `cfg_half + 1` system clock cycles.
- R5: `ss_n` falls one half period before a byte sequence begins. It stays low between bytes that are chained back to back. It rises one half period after the last byte, when nothing is pending.
- R6: `irq_tx` sets when the holding byte is moved into the shift register, which leaves the holding register empty. A write on `tx_wr` clears `irq_tx`.
- R7: With `cfg_txmode = 1`, the master stops at a byte boundary if the holding register is empty, and `rx_rd` never starts a transfer.
- R8: With `cfg_txmode = 0`, a pulse on `rx_rd` requests one byte. If the holding register is empty, 0xFF is transmitted.
- R9: `irq_rx` sets when a received byte enters `rx_data`, and a pulse on `rx_rd` clears it.
- R10: `flag_ovf` sets when a byte is handed off while `irq_rx` is still 1. It clears when `ovf_clr` is pulsed.
- R11: On overflow, `cfg_overwrite = 0` keeps the old `rx_data`, and `cfg_overwrite = 1` replaces it with the new byte.
- R12: With `cfg_early = 1`, the receive hand-off happens on the last sampling edge. This is one half period (`cfg_half + 1` cycles) earlier than with `cfg_early = 0`, where the hand-off happens at the end of the byte.
- R13: `busy` is 1 whenever `ss_n` is low or the transmit holding register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: sample on first edge; 1: sample on second edge |
| cfg_txmode | input | 1 | 1: transmit-initiated; 0: read-initiated |
| cfg_overwrite | input | 1 | On overflow, 1 replaces and 0 drops the new byte |
| cfg_early | input | 1 | Receive hand-off on last sampling edge |
| cfg_half | input | DIVW | Half period of `sclk` minus one, in system clocks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | W | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| ovf_clr | input | 1 | Write-one-to-clear for `flag_ovf` |
| rx_data | output | W | Receive holding register |
| irq_tx | output | 1 | Transmit holding register emptied |
| irq_rx | output | 1 | Received byte waiting |
| flag_ovf | output | 1 | Receive overflow |
| busy | output | 1 | Transfer active or byte pending |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions take several input conditions for granted:
- `cfg_half` and the other configuration bits stay fixed while `busy` is high.
- `tx_wr`, `rx_rd` and `ovf_clr` are single-cycle pulses.
- A write does not arrive in the same cycle as a load from an idle link.

The stimulus keeps within these conditions. It changes configuration only after waiting for `busy` low and `ss_n` high, and it drives every strobe for exactly one cycle between falling clock edges. A behavioural slave in the bench follows `sclk` in all four polarity and phase settings. It returns known bytes, so both serial directions are compared against values computed in the bench.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } spim_state_e;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt >= half)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt >= half);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick && run && (half != '0) && $stable(half) |=> !tick); // R4
endmodule

// File: rtl/spim_rxpath.sv
module spim_rxpath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] din,
    input  logic         rd,
    input  logic         clr_ovf,
    input  logic         overwrite,
    output logic [W-1:0] hold_q,
    output logic         full_q,
    output logic         ovf_q
);
    logic collide;
    assign collide = ld && full_q && !rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (clr_ovf)
                ovf_q <= 1'b0;
            if (ld) begin
                full_q <= 1'b1;
                if (collide) begin
                    ovf_q <= 1'b1;
                    if (overwrite)
                        hold_q <= din;
                end else begin
                    hold_q <= din;
                end
            end else if (rd) begin
                full_q <= 1'b0;
            end
        end
    end

    AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> full_q); // R9
    AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ld && full_q && !rd |=> ovf_q); // R10
    AST_DISCARD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ld && full_q && !rd && !overwrite |=> hold_q == $past(hold_q)); // R11
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
    import spim_pkg::*;
#(
    parameter int W    = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic            cfg_txmode,
    input  logic            cfg_overwrite,
    input  logic            cfg_early,
    input  logic [DIVW-1:0] cfg_half,
    input  logic            tx_wr,
    input  logic [W-1:0]    tx_data,
    input  logic            rx_rd,
    input  logic            ovf_clr,
    output logic [W-1:0]    rx_data,
    output logic            irq_tx,
    output logic            irq_rx,
    output logic            flag_ovf,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic            ss_n
);
    localparam int HALVES = 2 * W;
    localparam int HW     = $clog2(HALVES);
    localparam logic [HW-1:0] H_LAST = HW'(HALVES - 1);
    localparam logic [HW-1:0] H_SAMP = HW'(HALVES - 2);

    spim_state_e state, nxt;
    logic [HW-1:0] h;
    logic [W-1:0]  tx_hold, tx_sr, rx_sr, rx_byte;
    logic          tx_full, rd_req, irq_tx_q, ss_q;
    logic          tick, start_ok, last_half, load_now, rx_ld;

    spim_clkgen #(.DIVW(DIVW)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != ST_IDLE),
        .half (cfg_half),
        .tick (tick)
    );

    assign start_ok  = tx_full || (!cfg_txmode && rd_req);
    assign last_half = (h == H_LAST);
    assign load_now  = start_ok &&
                       ((state == ST_IDLE) || (state == ST_SHIFT && tick && last_half));
    assign rx_ld     = (state == ST_SHIFT) && tick && (cfg_early ? (h == H_SAMP) : last_half);
    assign rx_byte   = cfg_early ? {rx_sr[W-2:0], miso} : rx_sr;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_ok) nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && last_half && !start_ok) nxt = ST_TRAIL;
            ST_TRAIL: if (tick) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            tx_full  <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rd_req   <= 1'b0;
            irq_tx_q <= 1'b0;
            ss_q     <= 1'b1;
            h        <= '0;
        end else begin
            if (tx_wr) begin
                tx_hold <= tx_data;
                tx_full <= 1'b1;
            end else if (load_now && tx_full) begin
                tx_full <= 1'b0;
            end

            if (tx_wr)
                irq_tx_q <= 1'b0;
            else if (load_now && tx_full)
                irq_tx_q <= 1'b1;

            if (load_now)
                rd_req <= 1'b0;
            else if (rx_rd && !cfg_txmode)
                rd_req <= 1'b1;

            if (load_now)
                tx_sr <= tx_full ? tx_hold : '1;
            else if (state == ST_SHIFT && tick && h[0] && !last_half)
                tx_sr <= {tx_sr[W-2:0], 1'b0};

            if (state == ST_SHIFT && tick && !h[0])
                rx_sr <= {rx_sr[W-2:0], miso};

            if (state != ST_SHIFT)
                h <= '0;
            else if (tick)
                h <= last_half ? '0 : h + 1'b1;

            if (state == ST_IDLE && start_ok)
                ss_q <= 1'b0;
            else if (state == ST_TRAIL && tick)
                ss_q <= 1'b1;
        end
    end

    spim_rxpath #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (rx_ld),
        .din      (rx_byte),
        .rd       (rx_rd),
        .clr_ovf  (ovf_clr),
        .overwrite(cfg_overwrite),
        .hold_q   (rx_data),
        .full_q   (irq_rx),
        .ovf_q    (flag_ovf)
    );

    assign sclk   = (state == ST_SHIFT) ? (cfg_cpol ^ h[0] ^ cfg_cpha) : cfg_cpol;
    assign mosi   = tx_sr[W-1];
    assign ss_n   = ss_q;
    assign irq_tx = irq_tx_q;
    assign busy   = (state != ST_IDLE) || tx_full;

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> sclk == cfg_cpol); // R2
    AST_STALL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_txmode && state == ST_SHIFT && tick && last_half && !tx_full && !tx_wr
        |=> state == ST_TRAIL); // R7
    AST_TX_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && tx_full && !tx_wr |=> irq_tx && !busy == 1'b0); // R6
    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n |-> busy); // R13
endmodule

// File: tb/tb_spi_dbuf_master.sv
module tb_spi_dbuf_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_txmode = 1'b1;
    logic       cfg_overwrite = 1'b0, cfg_early = 1'b0;
    logic [7:0] cfg_half = 8'd1;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, ovf_clr = 1'b0, miso = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       irq_tx, irq_rx, flag_ovf, busy, sclk, mosi, ss_n;

    int n_checks = 0, n_fail = 0;

    spi_dbuf_master dut (.*);

    always #10 clk = ~clk;

    // behavioural slave
    logic [7:0] s_next = 8'h00, s_tx = 8'h00, s_rx = 8'h00, s_last = 8'h00;
    int s_cnt = 0, k = 0, ss_rises = 0;

    always @(posedge ss_n) ss_rises++;

    always @(negedge ss_n) begin
        k = 0;
        s_tx = s_next;
        if (!cfg_cpha) miso = s_tx[7];
    end

    always @(sclk) begin
        if (ss_n === 1'b0) begin
            if (k % 2 == 0) begin
                if (cfg_cpha) begin miso = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
                else s_rx = {s_rx[6:0], mosi};
            end else begin
                if (cfg_cpha) s_rx = {s_rx[6:0], mosi};
                else begin s_tx = {s_tx[6:0], 1'b0}; miso = s_tx[7]; end
            end
            k++;
            if (k == 16) begin
                k = 0;
                s_last = s_rx;
                s_cnt++;
                s_tx = s_next;
                if (!cfg_cpha) miso = s_tx[7];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_wr(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while ((busy || !ss_n) && n < 5000);
        if (n >= 5000) chk("wait_idle timeout", 0, 1);
    endtask

    task automatic rx_to_flag(input logic [7:0] b, output int cyc);
        cyc = 0;
        pulse_wr(b);
        while (ss_n) @(negedge clk);
        while (!irq_rx && cyc < 2000) begin @(negedge clk); cyc++; end
        wait_idle();
    endtask

    // {cpol, cpha, master byte, slave byte}
    localparam logic [17:0] VEC [4] = '{
        {1'b0, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'h81, 8'hC3},
        {1'b1, 1'b0, 8'h5A, 8'h96},
        {1'b1, 1'b1, 8'h7E, 8'h01}
    };

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int r0, c0, t0, t1, low;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ss_n", ss_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 irq_tx", irq_tx, 0);
        chk("R1 irq_rx", irq_rx, 0);
        chk("R1 flag_ovf", flag_ovf, 0);
        chk("R1 busy", busy, 0);

        // R2 / R3 all four modes from the vector table
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cfg_cpol = VEC[i][17];
            cfg_cpha = VEC[i][16];
            s_next   = VEC[i][7:0];
            @(negedge clk);
            chk("R2 sclk parked", sclk, VEC[i][17]);
            c0 = s_cnt;
            pulse_wr(VEC[i][15:8]);
            wait_idle();
            chk("R2 mosi byte", s_last, VEC[i][15:8]);
            chk("R2 frame count", s_cnt - c0, 1);
            chk("R3 miso byte", rx_data, VEC[i][7:0]);
            chk("R9 irq_rx set", irq_rx, 1);
            pulse_rd();
            chk("R9 irq_rx cleared", irq_rx, 0);
        end
        cfg_cpol = 1'b0; cfg_cpha = 1'b0;

        // R13 / R6 / R5: load timing and chained bytes
        s_next = 8'h44;
        r0 = ss_rises; c0 = s_cnt;
        pulse_wr(8'h12);
        chk("R13 busy with byte pending", busy, 1);
        @(negedge clk);
        chk("R6 irq_tx after load", irq_tx, 1);
        chk("R5 ss_n low", ss_n, 0);
        pulse_wr(8'h34);
        chk("R6 irq_tx cleared by write", irq_tx, 0);
        wait_idle();
        chk("R5 single select window", ss_rises - r0, 1);
        chk("R5 two chained bytes", s_cnt - c0, 2);
        chk("R2 second byte", s_last, 8'h34);
        pulse_clr();
        pulse_rd();

        // R7: stall, and rx_rd ignored in transmit-initiated mode
        r0 = ss_rises; c0 = s_cnt;
        pulse_wr(8'h55);
        wait_idle();
        chk("R7 stop after one byte", s_cnt - c0, 1);
        chk("R7 select released", ss_rises - r0, 1);
        pulse_rd();
        low = 0;
        for (int j = 0; j < 40; j++) begin @(negedge clk); if (!ss_n) low++; end
        chk("R7 rx_rd starts nothing", low, 0);

        // R8: read-initiated fill byte
        cfg_txmode = 1'b0;
        c0 = s_cnt;
        pulse_rd();
        wait_idle();
        chk("R8 fill byte sent", s_last, 8'hFF);
        chk("R8 one byte", s_cnt - c0, 1);
        cfg_txmode = 1'b1;
        pulse_rd();
        chk("R9 empty after read", irq_rx, 0);

        // R10 / R11 discard
        cfg_overwrite = 1'b0;
        s_next = 8'h11; pulse_wr(8'hA0); wait_idle();
        s_next = 8'h22; pulse_wr(8'hA1); wait_idle();
        chk("R10 overflow set", flag_ovf, 1);
        chk("R11 discard keeps old", rx_data, 8'h11);
        pulse_clr();
        chk("R10 overflow cleared", flag_ovf, 0);
        pulse_rd();

        // R11 overwrite
        cfg_overwrite = 1'b1;
        s_next = 8'h33; pulse_wr(8'hB0); wait_idle();
        s_next = 8'h66; pulse_wr(8'hB1); wait_idle();
        chk("R11 overwrite replaces", rx_data, 8'h66);
        chk("R10 overflow set again", flag_ovf, 1);
        pulse_clr();
        pulse_rd();
        cfg_overwrite = 1'b0;

        // R4 divider
        cfg_half = 8'd3;
        pulse_wr(8'hC5);
        while (!sclk) @(negedge clk);
        t0 = 0;
        while (sclk) begin @(negedge clk); t0++; end
        chk("R4 half period cycles", t0, 4);
        wait_idle();
        pulse_rd();

        // R12 early hand-off
        cfg_early = 1'b0;
        rx_to_flag(8'h0F, t0);
        pulse_rd();
        cfg_early = 1'b1;
        rx_to_flag(8'hF0, t1);
        chk("R12 early by one half period", t0 - t1, 4);
        chk("R12 early byte value", rx_data, 8'h66);
        pulse_rd();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule